// File: doc/BRIEF.md
# Scanline-Approximating Interrupt Timer

This block is an interrupt timer for a cartridge memory mapper, clocked from the CPU side. An 8-bit value counts upwards. When it passes 0xFF it raises an interrupt request and reloads itself from an 8-bit reload register. In line mode, a prescaler turns CPU cycles into ticks that come close to one video line each. The prescaler does not divide by one fixed ratio. It walks through three periods in turn: 114 CPU cycles, 114 CPU cycles, then 113 CPU cycles. Over three lines the average matches the line length. In cycle mode the value advances once for every CPU cycle.

The host decodes the mapper addresses and drives one write strobe for each register: reload low nibble, reload high nibble, control, and acknowledge. All of them share one data bus. A CPU clock enable marks the cycles that count. The interrupt output is a level. Software clears it by writing the control register or the acknowledge register.

Top module: `line_irq_timer`

## Requirements
- R1: While reset is low and after it is released, `irq` is 0, the control bits are 0 and the timer does not count.
- R2: With control bit 1 (enable) at 0, the value and the prescaler hold and `irq` never rises, in either mode.
- R3: With control bits 1 and 2 set (cycle mode), the value rises by one on each enabled CPU cycle. With a reload of 0xFD, `irq` rises on the third enabled cycle after the control write.
- R4: With control bit 1 set and bit 2 clear (line mode), ticks follow a repeating period pattern of 114, 114 and 113 enabled cycles, counted from the control write. With a reload of 0xFF, `irq` rises after 114, 228, 341, 455, 569 and 682 cycles.
- R5: When the value passes 0xFF it reloads from the reload register. The next overflow then comes 256 minus the reload value counting steps later.
- R6: `irq` stays high until a control or acknowledge write. Either write clears it on the next edge. If an overflow lands in the same cycle as an acknowledge, `irq` stays high.
- R7: An acknowledge write copies control bit 0 into the enable bit 1. The counting step of that same cycle still takes place.
- R8: A control write with bit 1 set loads the value from the reload register and sets the prescaler and its phase to zero. No counting step takes place in any cycle that has a control write.
- R9: The reload register is written in two halves: its low nibble and its high nibble each come from `wdata[3:0]` under their own strobes. `wdata[7:4]` is ignored.
- R10: While `cpu_ce` is 0, the value, the prescaler and the phase hold. Register writes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_ce | input | 1 | One CPU cycle elapses in this clock |
| wr_latch_lo | input | 1 | Write `wdata[3:0]` into the low reload nibble |
| wr_latch_hi | input | 1 | Write `wdata[3:0]` into the high reload nibble |
| wr_ctrl | input | 1 | Write control bits from `wdata[2:0]`; clears `irq` |
| wr_ack | input | 1 | Acknowledge: clears `irq`, copies control bit 0 into the enable bit |
| wdata | input | 8 | Write data shared by all strobes |
| irq | output | 1 | Interrupt request, active high, level |

## Verification
Every register write and every counting step takes effect at the rising edge of its own cycle. `irq` therefore shows the change one edge later, on the same edge that the overflow step happens. The bench drives inputs and samples `irq` on falling edges. It keeps a running count of edges since the last control write. For each expected tick at edge T, it checks `irq` low after edge T-1 and high after edge T. This pins each line period, including the short third period, to a single cycle. Acknowledge edges that fall inside a period are counted as counting cycles. The checks on reload and cycle mode place their samples two and three edges after the write for the same reason.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
   // control register bit positions
   localparam int BIT_ACK_EN = 0;
   localparam int BIT_EN     = 1;
   localparam int BIT_CYC    = 2;

   typedef struct packed {
      logic cyc;     // 1: count CPU cycles, 0: count prescaled lines
      logic en;      // counting enabled
      logic ack_en;  // value copied into en by an acknowledge
   } lirq_ctrl_t;
endpackage

// File: rtl/lirq_regs.sv
module lirq_regs
   import lirq_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              wr_ctrl,
   input  logic              wr_ack,
   input  logic [DATA_W-1:0] wdata,
   output lirq_ctrl_t        ctrl,
   output logic [CNT_W-1:0]  latch,
   output logic              restart,
   output logic              irq_clr
);
   localparam int HALF = CNT_W / 2;

   logic [1:0] wr_half;
   assign wr_half = {wr_hi, wr_lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch <= '0;
      end else begin
         for (int h = 0; h < 2; h++) begin
            if (wr_half[h]) latch[h*HALF +: HALF] <= wdata[HALF-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_ctrl) begin
         ctrl.cyc    <= wdata[BIT_CYC];
         ctrl.en     <= wdata[BIT_EN];
         ctrl.ack_en <= wdata[BIT_ACK_EN];
      end else if (wr_ack) begin
         ctrl.en <= ctrl.ack_en;
      end
   end

   assign restart = wr_ctrl && wdata[BIT_EN];
   assign irq_clr = wr_ctrl || wr_ack;

   logic unused_wdata;
   assign unused_wdata = ^wdata;
endmodule

// File: rtl/lirq_prescaler.sv
module lirq_prescaler #(
   parameter int LONG_PERIOD  = 114,
   parameter int SHORT_PERIOD = 113,
   parameter int NUM_PHASES   = 3,
   localparam int PS_W = $clog2(LONG_PERIOD + 1),
   localparam int PH_W = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic            restart,
   output logic            tick,
   output logic [PS_W-1:0] ps_o,
   output logic [PH_W-1:0] phase_o
);
   logic [PS_W-1:0] ps_q;
   logic [PS_W-1:0] ps_inc;
   logic [PS_W-1:0] term;
   logic [PH_W-1:0] phase_q;
   logic            at_term;

   assign ps_inc  = ps_q + 1'b1;
   assign at_term = (ps_inc == term);
   assign tick    = step && !restart && at_term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_q <= '0;
      end else if (restart) begin
         ps_q <= '0;
      end else if (step) begin
         ps_q <= at_term ? '0 : ps_inc;
      end
   end

   generate
      if (NUM_PHASES > 1) begin : g_phased
         logic last_phase;
         assign last_phase = (phase_q == PH_W'(NUM_PHASES - 1));
         assign term = last_phase ? PS_W'(SHORT_PERIOD) : PS_W'(LONG_PERIOD);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (restart) begin
               phase_q <= '0;
            end else if (tick) begin
               phase_q <= last_phase ? '0 : phase_q + 1'b1;
            end
         end
      end else begin : g_fixed
         assign phase_q = '0;
         assign term    = PS_W'(LONG_PERIOD);
      end
   endgenerate

   assign ps_o    = ps_q;
   assign phase_o = phase_q;
endmodule

// File: rtl/lirq_counter.sv
module lirq_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             restart,
   input  logic             irq_clr,
   input  logic [CNT_W-1:0] latch,
   output logic [CNT_W-1:0] value,
   output logic             ovf,
   output logic             irq
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] value_q;

   assign ovf = step && !restart && (value_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q <= '0;
      end else if (restart || ovf) begin
         value_q <= latch;
      end else if (step) begin
         value_q <= value_q + 1'b1;
      end
   end

   // a new overflow outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else if (ovf) begin
         irq <= 1'b1;
      end else if (irq_clr) begin
         irq <= 1'b0;
      end
   end

   assign value = value_q;
endmodule

// File: rtl/line_irq_timer.sv
module line_irq_timer
   import lirq_pkg::*;
#(
   parameter int CNT_W         = 8,
   parameter int DATA_W        = 8,
   parameter int LONG_PERIOD   = 114,
   parameter int SHORT_PERIOD  = 113,
   parameter int NUM_PHASES    = 3,
   parameter bit CYCLE_MODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_ce,
   input  logic              wr_latch_lo,
   input  logic              wr_latch_hi,
   input  logic              wr_ctrl,
   input  logic              wr_ack,
   input  logic [DATA_W-1:0] wdata,
   output logic              irq
);
   localparam int PS_W = $clog2(LONG_PERIOD + 1);
   localparam int PH_W = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1;

   initial begin
      assert (CNT_W % 2 == 0 && CNT_W >= 2) else $error("CNT_W must be even");
      assert (DATA_W >= CNT_W / 2 && DATA_W > BIT_CYC) else $error("DATA_W too narrow");
      assert (SHORT_PERIOD >= 1 && SHORT_PERIOD <= LONG_PERIOD) else $error("bad periods");
      assert (NUM_PHASES >= 1) else $error("NUM_PHASES must be positive");
   end

   lirq_ctrl_t       ctrl;
   logic [CNT_W-1:0] latch;
   logic             restart;
   logic             irq_clr;
   logic             cyc_sel;
   logic             count_go;
   logic             ps_step;
   logic             ps_tick;
   logic             cnt_step;
   logic             ovf;
   logic [CNT_W-1:0] value;
   logic [PS_W-1:0]  ps;
   logic [PH_W-1:0]  phase;

   lirq_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (wr_latch_lo),
      .wr_hi   (wr_latch_hi),
      .wr_ctrl (wr_ctrl),
      .wr_ack  (wr_ack),
      .wdata   (wdata),
      .ctrl    (ctrl),
      .latch   (latch),
      .restart (restart),
      .irq_clr (irq_clr)
   );

   generate
      if (CYCLE_MODE_EN) begin : g_cyc_mode
         assign cyc_sel = ctrl.cyc;
      end else begin : g_line_only
         logic unused_cyc;
         assign unused_cyc = ctrl.cyc;
         assign cyc_sel    = 1'b0;
      end
   endgenerate

   // no counting step in a cycle that writes the control register
   assign count_go = cpu_ce && ctrl.en && !wr_ctrl;
   assign ps_step  = count_go && !cyc_sel;
   assign cnt_step = cyc_sel ? count_go : ps_tick;

   lirq_prescaler #(
      .LONG_PERIOD  (LONG_PERIOD),
      .SHORT_PERIOD (SHORT_PERIOD),
      .NUM_PHASES   (NUM_PHASES)
   ) u_ps (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (ps_step),
      .restart (restart),
      .tick    (ps_tick),
      .ps_o    (ps),
      .phase_o (phase)
   );

   lirq_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (cnt_step),
      .restart (restart),
      .irq_clr (irq_clr),
      .latch   (latch),
      .value   (value),
      .ovf     (ovf),
      .irq     (irq)
   );
endmodule

// File: rtl/lirq_chk.sv
module lirq_chk #(
   parameter int CNT_W       = 8,
   parameter int DATA_W      = 8,
   parameter int LONG_PERIOD = 114,
   parameter int NUM_PHASES  = 3,
   parameter int PS_W        = 7,
   parameter int PH_W        = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ce,
   input logic              wr_ctrl,
   input logic              wr_ack,
   input logic [DATA_W-1:0] wdata,
   input logic              irq,
   input logic              en,
   input logic              ovf,
   input logic [CNT_W-1:0]  value,
   input logic [CNT_W-1:0]  latch,
   input logic [PS_W-1:0]   ps,
   input logic [PH_W-1:0]   phase
);
   // R2
   irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !irq) |=> !irq);

   // R6
   irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr_ctrl && !wr_ack) |=> irq);

   // R6
   ctrl_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> !irq);

   // R6
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack && !ovf) |=> !irq);

   // R4
   ps_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ps < PS_W'(LONG_PERIOD)) && (phase < PH_W'(NUM_PHASES)));

   // R10
   no_ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_ce && !wr_ctrl) |=> ($stable(value) && $stable(ps) && $stable(phase)));

   // R5
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (value == $past(latch) && irq));

   // R8
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wdata[lirq_pkg::BIT_EN]) |=> (value == $past(latch) && ps == '0 && phase == '0));
endmodule

bind line_irq_timer lirq_chk #(
   .CNT_W       (CNT_W),
   .DATA_W      (DATA_W),
   .LONG_PERIOD (LONG_PERIOD),
   .NUM_PHASES  (NUM_PHASES),
   .PS_W        (PS_W),
   .PH_W        (PH_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cpu_ce  (cpu_ce),
   .wr_ctrl (wr_ctrl),
   .wr_ack  (wr_ack),
   .wdata   (wdata),
   .irq     (irq),
   .en      (ctrl.en),
   .ovf     (ovf),
   .value   (value),
   .latch   (latch),
   .ps      (ps),
   .phase   (phase)
);

// File: tb/tb_line_irq_timer.sv
module tb_line_irq_timer;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       cpu_ce;
   logic       wr_latch_lo;
   logic       wr_latch_hi;
   logic       wr_ctrl;
   logic       wr_ack;
   logic [7:0] wdata;
   logic       irq;
   int         total = 0;
   int         bad = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   line_irq_timer dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_ce      (cpu_ce),
      .wr_latch_lo (wr_latch_lo),
      .wr_latch_hi (wr_latch_hi),
      .wr_ctrl     (wr_ctrl),
      .wr_ack      (wr_ack),
      .wdata       (wdata),
      .irq         (irq)
   );

   task automatic chk(input string req, input logic exp);
      total++;
      if (irq !== exp) begin
         bad++;
         $display("FAIL %s irq actual=%0b expected=%0b at %0t", req, irq, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic put_ctrl(input logic [7:0] v);
      wdata = v; wr_ctrl = 1'b1;
      @(negedge clk);
      wr_ctrl = 1'b0;
   endtask

   task automatic put_ack();
      wr_ack = 1'b1;
      @(negedge clk);
      wr_ack = 1'b0;
   endtask

   task automatic put_latch(input logic [7:0] lo, input logic [7:0] hi);
      put_ctrl(8'h00);
      wdata = lo; wr_latch_lo = 1'b1;
      @(negedge clk);
      wr_latch_lo = 1'b0;
      wdata = hi; wr_latch_hi = 1'b1;
      @(negedge clk);
      wr_latch_hi = 1'b0;
   endtask

   // expect a line tick at edge t counted from the last control write
   task automatic expect_tick(input int t, input int hold, ref int cur);
      cyc(t - 1 - cur);
      chk("R4 before tick", 1'b0);
      cyc(1);
      chk("R4 at tick", 1'b1);
      if (hold > 0) begin
         cyc(hold);
         chk("R6 level held", 1'b1);
      end
      put_ack();
      cur = t + 1 + hold;
   endtask

   task automatic t_reset();
      chk("R1 in reset", 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 after reset", 1'b0);
      cyc(300);
      chk("R1 idle after reset", 1'b0);
   endtask

   task automatic t_disabled();
      put_latch(8'h0F, 8'h0F);
      put_ctrl(8'b100);
      cyc(20);
      chk("R2 cycle mode disabled", 1'b0);
      put_ctrl(8'b000);
      cyc(300);
      chk("R2 line mode disabled", 1'b0);
   endtask

   task automatic t_cycle_reload();
      put_latch(8'hAD, 8'h5F);   // R9: upper bits ignored -> 0xFD
      put_ctrl(8'b111);
      cyc(2);
      chk("R3 R9 before overflow", 1'b0);
      cyc(1);
      chk("R3 R9 overflow third cycle", 1'b1);
      put_ack();
      chk("R6 ack clears", 1'b0);
      cyc(1);
      chk("R5 reload not yet", 1'b0);
      cyc(1);
      chk("R5 reload overflow", 1'b1);
   endtask

   task automatic t_ack_copy();
      put_latch(8'h0D, 8'h0F);
      put_ctrl(8'b110);
      cyc(3);
      chk("R7 overflow", 1'b1);
      put_ack();
      chk("R7 ack clears", 1'b0);
      cyc(30);
      chk("R7 ack disabled counting", 1'b0);
      put_ack();
      cyc(30);
      chk("R7 still disabled", 1'b0);
   endtask

   task automatic t_ack_race();
      put_latch(8'h0F, 8'h0F);
      put_ctrl(8'b111);
      cyc(1);
      chk("R6 overflow each cycle", 1'b1);
      put_ack();
      chk("R6 overflow beats ack", 1'b1);
      put_ack();
      chk("R6 overflow beats ack again", 1'b1);
      put_ctrl(8'b001);
      chk("R6 ctrl write clears", 1'b0);
   endtask

   task automatic t_line();
      int cur;
      put_latch(8'h0F, 8'h0F);
      put_ctrl(8'b011);
      cur = 0;
      expect_tick(114, 50, cur);
      expect_tick(228, 0, cur);
      expect_tick(341, 0, cur);
      expect_tick(455, 0, cur);
      expect_tick(569, 0, cur);
      expect_tick(682, 0, cur);
   endtask

   task automatic t_restart();
      int cur;
      put_latch(8'h0F, 8'h0F);
      put_ctrl(8'b011);
      cur = 0;
      expect_tick(114, 0, cur);
      expect_tick(228, 0, cur);
      // phase now points at the short period; restart must clear it (R8)
      put_ctrl(8'b011);
      cur = 0;
      expect_tick(114, 0, cur);
      cyc(60);
      put_ctrl(8'b011);
      chk("R8 mid-period restart", 1'b0);
      cur = 0;
      expect_tick(114, 0, cur);
      put_latch(8'h0D, 8'h0F);
      put_ctrl(8'b111);
      cyc(2);
      put_ctrl(8'b111);       // R8 reload value from 0xFF back to 0xFD
      cyc(2);
      chk("R8 reload before overflow", 1'b0);
      cyc(1);
      chk("R8 reload overflow", 1'b1);
   endtask

   task automatic t_ce();
      put_latch(8'h0E, 8'h0F);
      cpu_ce = 1'b0;
      put_ctrl(8'b110);
      cyc(10);
      chk("R10 hold without ce", 1'b0);
      cpu_ce = 1'b1;
      cyc(1);
      chk("R10 first enabled cycle", 1'b0);
      cyc(1);
      chk("R10 overflow after gap", 1'b1);
   endtask

   initial begin
      rst_n = 1'b0; cpu_ce = 1'b1;
      wr_latch_lo = 1'b0; wr_latch_hi = 1'b0;
      wr_ctrl = 1'b0; wr_ack = 1'b0; wdata = '0;
      cyc(3);
      t_reset();
      t_disabled();
      t_cycle_reload();
      t_ack_copy();
      t_ack_race();
      t_line();
      t_restart();
      t_ce();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule